// File: doc/BRIEF.md
# Serial Codec Link Global Control and Status

This block owns the two chip-wide registers of a serial codec link controller that serves one modem capture channel and one modem playback channel. The control register drives the link's cold-reset, warm-reset and shut-off outputs and holds the interrupt enables. The status register gathers live codec-ready inputs, sticky resume, GPI-change and read-timeout events, the power-down semaphores, a constant capability field, and the level interrupt lines of the two DMA channels.

Software reaches both registers through a plain single-cycle register port. A write with `wr_en` high lands on the next rising clock edge. `rdata` is a combinational view of the register selected by `reg_addr`, and reading has no side effects. The block folds every active interrupt source into one level `irq` output.

Top module: `link_glob_regs`

## Requirements
- R1: The control register at address CTL_ADDR (0x3C) resets to 0. Bits 0 (GPI interrupt enable), 1 (cold-reset release), 3 (link shut-off), 4, 5 and 6 (primary, secondary and tertiary resume interrupt enables) read back the value last written to them. Bits 7 to 31 read 0.
- R2: `cold_rst_n` is low while control bit 1 is 0, which includes the time after reset. It goes high on the clock edge that stores a 1 in bit 1.
- R3: A write of 1 to control bit 2 while no pulse is running starts a warm-reset pulse. `warm_rst` is high and bit 2 reads 1 for exactly WARM_CYCLES cycles, starting the cycle after the write, and then both clear by themselves. Writing 0 to bit 2 has no effect. Writing 1 during a pulse neither restarts nor extends it.
- R4: `link_off` equals control bit 3. A warm-reset request is ignored when the same write sets bit 3. While bit 3 is set, the codec-ready status bits read 0.
- R5: Status bits 8, 9 and 28 show `codec_rdy[0]`, `codec_rdy[1]` and `codec_rdy[2]`, each sampled one clock earlier.
- R6: Five sticky status bits are set by a one-cycle event pulse and cleared by writing 1 to them at STS_ADDR (0x40): bit 0 by `gpi_evt`, bits 10, 11 and 29 by `resume_evt[0..2]`, and bit 15 by `rd_timeout`. Writing 0 leaves them unchanged. When an event and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R7: Status bit 1 shows `ch_irq[0]` (capture) and status bit 2 shows `ch_irq[1]` (playback), live in the same cycle.
- R8: Status bits 16 and 17 (audio and modem power-down semaphores) read back the value last written to them and reset to 0. Bits 20 to 23 always read the CAPS parameter, and writes to them have no effect.
- R9: `irq` is high when either `ch_irq` line is high, when a resume bit is set while its enable bit (4, 5 or 6) is set, or when the GPI-change bit is set while enable bit 0 is set.
- R10: Reads at any address other than the two registers return 0, and writes there change nothing. Unused status bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address for read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the addressed register |
| codec_rdy | input | 3 | Codec-ready inputs (primary, secondary, tertiary) |
| resume_evt | input | 3 | Resume event pulses (primary, secondary, tertiary) |
| gpi_evt | input | 1 | GPI change event pulse |
| rd_timeout | input | 1 | Codec read timeout event pulse |
| ch_irq | input | 2 | Channel interrupt levels (0 capture, 1 playback) |
| cold_rst_n | output | 1 | Link cold reset, active low |
| warm_rst | output | 1 | Link warm reset pulse |
| link_off | output | 1 | Link shut-off |
| irq | output | 1 | Summary interrupt |

## Verification
Two functions can meet in the same cycle: an event pulse that sets a sticky status bit, and a write-one-to-clear aimed at that same bit. A second such meeting is a warm-reset request in the same write that sets link shut-off. The bench provokes both on purpose, by pulsing `resume_evt` and `gpi_evt` in the cycle of a clearing write and by writing bits 2 and 3 together, and a later stretch of random traffic hits them by chance. A behavioural model compares every output and the addressed read word on every clock. Any field that differs is reported under its own requirement: set-wins for the sticky bits, and an ignored pulse for the link shut-off case.

// File: rtl/link_glob_pkg.sv
package link_glob_pkg;
  // control register bit positions
  localparam int C_GIE   = 0;
  localparam int C_COLD  = 1;
  localparam int C_WARM  = 2;
  localparam int C_LOFF  = 3;
  localparam int C_RIE0  = 4;
  localparam int C_RIE1  = 5;
  localparam int C_RIE2  = 6;
  localparam int CTL_W   = 7;
  // status register bit positions
  localparam int S_GPI   = 0;
  localparam int S_CAPI  = 1;
  localparam int S_PLYI  = 2;
  localparam int S_RDY0  = 8;
  localparam int S_RDY1  = 9;
  localparam int S_RES0  = 10;
  localparam int S_RES1  = 11;
  localparam int S_TMO   = 15;
  localparam int S_SEM0  = 16;
  localparam int S_CAPLO = 20;
  localparam int S_RDY2  = 28;
  localparam int S_RES2  = 29;
  // sticky vector ordering
  localparam int K_GPI   = 0;
  localparam int K_RES0  = 1;
  localparam int K_RES1  = 2;
  localparam int K_RES2  = 3;
  localparam int K_TMO   = 4;
  localparam int NSTK    = 5;
endpackage

// File: rtl/lgr_ctl.sv
module lgr_ctl
  import link_glob_pkg::*;
#(
  parameter int WARM_CYCLES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CTL_W-1:0] wd,
  output logic [CTL_W-1:0] ctl,
  output logic             warm_busy
);
  localparam int CW = $clog2(WARM_CYCLES + 1);

  logic [CTL_W-1:0] hold_q;
  logic [CW-1:0]    cnt_q;
  logic             start;

  assign warm_busy = (cnt_q != '0);
  assign start     = we && wd[C_WARM] && !wd[C_LOFF] && !warm_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (we) hold_q <= wd & ~(CTL_W'(1) << C_WARM);
      if (start)          cnt_q <= CW'(WARM_CYCLES);
      else if (warm_busy) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_comb begin
    ctl         = hold_q;
    ctl[C_WARM] = warm_busy;
  end

  p_warm_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wd[C_WARM] && !wd[C_LOFF] && !warm_busy) |=> warm_busy);
  p_warm_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wd[C_LOFF]) |=> !$rose(warm_busy));
endmodule

// File: rtl/lgr_sticky.sv
module lgr_sticky #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q[i] <= 1'b0;
      else if (set[i]) q[i] <= 1'b1;
      else if (clr[i]) q[i] <= 1'b0;
    end
  end

  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (set != '0) |=> ((q & $past(set)) == $past(set)));
  p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr & ~set) != '0) |=> ((q & $past(clr & ~set)) == '0));
endmodule

// File: rtl/lgr_rdy.sv
module lgr_rdy #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] rdy_in,
  input  logic         mask,
  output logic [N-1:0] rdy_out
);
  logic [N-1:0] smp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) smp_q <= '0;
    else        smp_q <= rdy_in;
  end

  assign rdy_out = mask ? '0 : smp_q;
endmodule

// File: rtl/link_glob_regs.sv
module link_glob_regs
  import link_glob_pkg::*;
#(
  parameter int          AW          = 8,
  parameter logic [7:0]  CTL_ADDR    = 8'h3C,
  parameter logic [7:0]  STS_ADDR    = 8'h40,
  parameter int          WARM_CYCLES = 16,
  parameter logic [3:0]  CAPS        = 4'h5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  input  logic [2:0]    codec_rdy,
  input  logic [2:0]    resume_evt,
  input  logic          gpi_evt,
  input  logic          rd_timeout,
  input  logic [1:0]    ch_irq,
  output logic          cold_rst_n,
  output logic          warm_rst,
  output logic          link_off,
  output logic          irq
);
  localparam logic [AW-1:0] A_CTL = AW'(CTL_ADDR);
  localparam logic [AW-1:0] A_STS = AW'(STS_ADDR);

  logic             ctl_we, sts_we;
  logic [CTL_W-1:0] ctl;
  logic             warm_busy;
  logic [NSTK-1:0]  stk, stk_set, stk_clr;
  logic [2:0]       rdy;
  logic [1:0]       sem_q;
  logic [31:0]      ctl_word, sts_word;

  assign ctl_we = wr_en && (reg_addr == A_CTL);
  assign sts_we = wr_en && (reg_addr == A_STS);

  lgr_ctl #(.WARM_CYCLES(WARM_CYCLES)) u_ctl (
    .clk(clk), .rst_n(rst_n), .we(ctl_we), .wd(wdata[CTL_W-1:0]),
    .ctl(ctl), .warm_busy(warm_busy)
  );

  assign stk_set = {rd_timeout, resume_evt[2], resume_evt[1], resume_evt[0], gpi_evt};
  assign stk_clr = {NSTK{sts_we}} &
                   {wdata[S_TMO], wdata[S_RES2], wdata[S_RES1], wdata[S_RES0], wdata[S_GPI]};

  lgr_sticky #(.W(NSTK)) u_stk (
    .clk(clk), .rst_n(rst_n), .set(stk_set), .clr(stk_clr), .q(stk)
  );

  lgr_rdy #(.N(3)) u_rdy (
    .clk(clk), .rst_n(rst_n), .rdy_in(codec_rdy), .mask(ctl[C_LOFF]), .rdy_out(rdy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sem_q <= '0;
    else if (sts_we) sem_q <= wdata[S_SEM0+1:S_SEM0];
  end

  always_comb begin
    ctl_word = '0;
    ctl_word[CTL_W-1:0] = ctl;
    sts_word = '0;
    sts_word[S_GPI]  = stk[K_GPI];
    sts_word[S_CAPI] = ch_irq[0];
    sts_word[S_PLYI] = ch_irq[1];
    sts_word[S_RDY0] = rdy[0];
    sts_word[S_RDY1] = rdy[1];
    sts_word[S_RDY2] = rdy[2];
    sts_word[S_RES0] = stk[K_RES0];
    sts_word[S_RES1] = stk[K_RES1];
    sts_word[S_RES2] = stk[K_RES2];
    sts_word[S_TMO]  = stk[K_TMO];
    sts_word[S_SEM0+1:S_SEM0]  = sem_q;
    sts_word[S_CAPLO+3:S_CAPLO] = CAPS;
    if (reg_addr == A_CTL)      rdata = ctl_word;
    else if (reg_addr == A_STS) rdata = sts_word;
    else                        rdata = '0;
  end

  assign cold_rst_n = ctl[C_COLD];
  assign warm_rst   = warm_busy;
  assign link_off   = ctl[C_LOFF];
  assign irq = (|ch_irq)
             | (stk[K_GPI]  & ctl[C_GIE])
             | (stk[K_RES0] & ctl[C_RIE0])
             | (stk[K_RES1] & ctl[C_RIE1])
             | (stk[K_RES2] & ctl[C_RIE2]);

  p_cold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> (cold_rst_n == $past(wdata[C_COLD])));
  p_rdy_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (link_off && reg_addr == A_STS) |-> (rdata[S_RDY1:S_RDY0] == 2'b00 && !rdata[S_RDY2]));
  p_chirq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|ch_irq) |-> irq);
endmodule

// File: tb/tb_link_glob_regs.sv
`timescale 1ns/1ps
module tb_link_glob_regs;
  localparam int WARM = 16;
  localparam logic [3:0] CAPS = 4'h5;

  logic clk = 0, rst_n = 0, wr_en = 0, gpi_evt = 0, rd_timeout = 0;
  logic [7:0]  reg_addr = 8'h3C;
  logic [31:0] wdata = 0, rdata;
  logic [2:0]  codec_rdy = 0, resume_evt = 0;
  logic [1:0]  ch_irq = 0;
  logic cold_rst_n, warm_rst, link_off, irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // behavioural model state
  int m_ctl = 0, m_cnt = 0, m_rdy = 0, m_sem = 0;
  bit m_stk [5];

  always #10 clk = ~clk;

  link_glob_regs #(.WARM_CYCLES(WARM), .CAPS(CAPS)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr), .wdata(wdata),
    .rdata(rdata), .codec_rdy(codec_rdy), .resume_evt(resume_evt), .gpi_evt(gpi_evt),
    .rd_timeout(rd_timeout), .ch_irq(ch_irq), .cold_rst_n(cold_rst_n),
    .warm_rst(warm_rst), .link_off(link_off), .irq(irq)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctl = 0; m_cnt = 0; m_rdy = 0; m_sem = 0;
      foreach (m_stk[i]) m_stk[i] = 0;
    end else begin
      bit [4:0] ev, cl;
      bit go;
      ev = {rd_timeout, resume_evt[2], resume_evt[1], resume_evt[0], gpi_evt};
      cl = (wr_en && reg_addr == 8'h40) ?
           {wdata[15], wdata[29], wdata[11], wdata[10], wdata[0]} : 5'b0;
      for (int i = 0; i < 5; i++)
        if (ev[i]) m_stk[i] = 1; else if (cl[i]) m_stk[i] = 0;
      go = wr_en && reg_addr == 8'h3C && wdata[2] && !wdata[3] && m_cnt == 0;
      if (m_cnt > 0) m_cnt--;
      if (go) m_cnt = WARM;
      if (wr_en && reg_addr == 8'h3C) m_ctl = int'(wdata[6:0]) & 'h7B;
      if (wr_en && reg_addr == 8'h40) m_sem = int'(wdata[17:16]);
      m_rdy = int'(codec_rdy);
    end
  end

  function automatic bit [31:0] exp_sts();
    bit [31:0] s = 0;
    bit [2:0] r = ((m_ctl >> 3) & 1) ? 3'b0 : 3'(m_rdy);
    s[0] = m_stk[0]; s[1] = ch_irq[0]; s[2] = ch_irq[1];
    s[8] = r[0]; s[9] = r[1]; s[28] = r[2];
    s[10] = m_stk[1]; s[11] = m_stk[2]; s[29] = m_stk[3]; s[15] = m_stk[4];
    s[17:16] = 2'(m_sem); s[23:20] = CAPS;
    return s;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit [31:0] ec, es;
    bit e_irq;
    ec = 32'(m_ctl) | ((m_cnt != 0) ? 32'h4 : 32'h0);
    es = exp_sts();
    e_irq = (|ch_irq) | (m_stk[0] & ec[0]) | (m_stk[1] & ec[4]) |
            (m_stk[2] & ec[5]) | (m_stk[3] & ec[6]);
    chk("R2 cold_rst_n", 32'(cold_rst_n), 32'(ec[1]));
    chk("R3 warm_rst",   32'(warm_rst),   32'(ec[2]));
    chk("R4 link_off",   32'(link_off),   32'(ec[3]));
    chk("R9 irq",        32'(irq),        32'(e_irq));
    if (reg_addr == 8'h3C) begin
      chk("R1 ctl read", rdata & ~32'h4, ec & ~32'h4);
      chk("R3 warm bit", rdata & 32'h4, ec & 32'h4);
    end else if (reg_addr == 8'h40) begin
      chk("R5 R4 codec ready", rdata & 32'h1000_0300, es & 32'h1000_0300);
      chk("R6 sticky",  rdata & 32'h2000_8C01, es & 32'h2000_8C01);
      chk("R7 channel", rdata & 32'h6, es & 32'h6);
      chk("R8 sem/caps", rdata & 32'h00F3_0000, es & 32'h00F3_0000);
      chk("R10 unused", rdata & ~32'h30F3_8F07, 32'h0);
    end else begin
      chk("R10 other addr", rdata, 32'h0);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
    compare();
    wr_en = 0; gpi_evt = 0; rd_timeout = 0; resume_evt = 0;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, logic [7:0] ra);
    wr_en = 1; reg_addr = a; wdata = d; tick(); reg_addr = ra;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #200_000_0;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk); compare();           // R1 R2 reset state
    idle(2);
    rst_n = 1;
    idle(1);
    reg_addr = 8'h40; idle(1);           // R8 caps, R10 zero status
    // R2 cold release, R1 enables
    wr(8'h3C, 32'hFFFF_FF73, 8'h3C); idle(1);
    // R3 warm pulse, repeat request during pulse
    wr(8'h3C, 32'h77, 8'h3C); idle(4);
    wr(8'h3C, 32'h77, 8'h3C); idle(WARM + 2);
    wr(8'h3C, 32'h73, 8'h3C); idle(2);   // R3 write 0: nothing
    // R4 warm with link off in same write, codec ready masked
    codec_rdy = 3'b111;
    wr(8'h3C, 32'h7E, 8'h40); idle(3);
    wr(8'h3C, 32'h73, 8'h40); idle(2);   // R5 visible again
    codec_rdy = 3'b010; idle(2);
    // R6 sticky set, R9 irq with enables
    resume_evt = 3'b001; tick(); idle(1);
    gpi_evt = 1; rd_timeout = 1; resume_evt = 3'b110; tick(); idle(1);
    wr(8'h40, 32'h0, 8'h40); idle(1);    // R6 write 0 no effect
    wr(8'h3C, 32'h02, 8'h40); idle(1);   // R9 enables off
    wr(8'h3C, 32'h73, 8'h40);
    // R6 set wins over clear in the same cycle
    resume_evt = 3'b001; gpi_evt = 1;
    wr(8'h40, 32'hFFFF_FFFF, 8'h40); idle(1);
    wr(8'h40, 32'h2000_8C01, 8'h40); idle(1);
    // R7 channel lines
    ch_irq = 2'b01; idle(1); ch_irq = 2'b10; idle(1); ch_irq = 2'b00; idle(1);
    // R8 semaphores and caps write attempt
    wr(8'h40, 32'h00F3_0000, 8'h40); idle(1);
    wr(8'h40, 32'h0001_0000, 8'h40); idle(1);
    // R10 other address
    wr(8'h20, 32'hFFFF_FFFF, 8'h20); reg_addr = 8'h3C; idle(1);
    reg_addr = 8'h40; idle(1);
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 9);
      codec_rdy  = 3'($urandom);
      ch_irq     = 2'($urandom);
      resume_evt = ($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'b0;
      gpi_evt    = ($urandom_range(0, 5) == 0);
      rd_timeout = ($urandom_range(0, 5) == 0);
      reg_addr   = (r < 4) ? 8'h3C : (r < 8) ? 8'h40 : 8'h08;
      wr_en      = ($urandom_range(0, 2) == 0);
      wdata      = $urandom;
      tick();
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule